// File: doc/BRIEF.md
# Single-Clock FIFO with Selectable Guards

This block is a first-in first-out word buffer running on one clock. A producer raises a write request with a data word; a consumer raises a read request and receives the oldest stored word on the read-data output. The read data arrives after a fixed latency and is not shown ahead. The block reports its fill level as a word count, plus full, empty and two threshold flags. Data width, depth and both thresholds are parameters.

Build-time switches set how the block treats misuse and edge cases. A write guard drops writes made while full. A read guard drops reads made while empty. A pass-through mode lets a full buffer take a read and a write in the same cycle and stay full; it takes effect only when the write guard is on. An extra output stage delays read data by one more cycle. With the guards off, the user must never request a write while full or a read while empty. A synchronous clear empties the buffer at once.

Top module: `sfifo_guarded`

## Requirements
- R1: With the output stage off, the word removed by an accepted read is on `rd_data` after the next rising clock edge. Words leave in the order they were written.
- R2: With the output stage on, the word removed by an accepted read is on `rd_data` two rising edges after the request. The order is the same as in R1.
- R3: `level` rises by 1 after an accepted write alone and falls by 1 after an accepted read alone. It is unchanged after an accepted read and write in the same cycle.
- R4: `full` is 1 exactly when `level` equals the depth, and `empty` is 1 exactly when `level` is 0. Both are registered. After reset, `level` is 0, `empty` is 1 and `full` is 0.
- R5: `almost_full` is 1 whenever `level` is greater than or equal to the parameter `AF_LEVEL`.
- R6: `almost_empty` is 1 whenever `level` is strictly less than the parameter `AE_LEVEL`.
- R7: With the write guard on, a write request made while full is ignored. `level` stays at the depth, and the stored words and their order are unchanged.
- R8: With the read guard on, a read request made while empty is ignored and `level` stays 0. A read and a write together on an empty buffer store the word and read nothing.
- R9: With pass-through and the write guard both on, a read and a write together on a full buffer remove the oldest word and store the new one. `full` stays 1.
- R10: `clr` high at a rising edge sets `level` to 0, `empty` to 1 and `full` to 0. It ignores any request made in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of pointers and level |
| wr_req | input | 1 | Write request |
| rd_req | input | 1 | Read request |
| wr_data | input | DW | Word to store |
| rd_data | output | DW | Word read out |
| full | output | 1 | Level equals depth |
| empty | output | 1 | Level is zero |
| almost_full | output | 1 | Level at or above AF_LEVEL |
| almost_empty | output | 1 | Level below AE_LEVEL |
| level | output | CW | Stored-word count |

## Verification
The bench runs the two build variants in the same run:
- **Guarded variant:** write guard, read guard and pass-through on, output stage off.
- **Unguarded variant:** both guards off and the output stage on.

The bench walks each variant through every level from empty to full and checks both threshold flags at every level. This catches a design that compares with the wrong inequality, because its flag would be one level off at the threshold. It writes while full and reads while empty. A missing guard would corrupt the level, or wrap a pointer and later return a stale word. It also does a read and a write together on a full buffer and on an empty buffer. A design that got these cases wrong would drop full, or would emit a word that was never written. Each returned word is checked against a reference queue at the latency expected for its variant, so an extra or missing pipeline stage shows up as wrong data.

// File: rtl/sfifo_pkg.sv
package sfifo_pkg;
  // Next ring position for a buffer of arbitrary depth.
  function automatic int unsigned ring_next(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Level after one cycle of accepted operations.
  function automatic int unsigned level_next(int unsigned c, logic w, logic r);
    int unsigned n;
    n = c;
    if (w) n = n + 1;
    if (r) n = n - 1;
    return n;
  endfunction

  function automatic logic at_or_above(int unsigned c, int unsigned thr);
    return c >= thr;
  endfunction

  function automatic logic strictly_below(int unsigned c, int unsigned thr);
    return c < thr;
  endfunction
endpackage

// File: rtl/sfifo_ctrl.sv
module sfifo_ctrl #(
  parameter int DEPTH        = 8,
  parameter int AW           = 3,
  parameter int CW           = 4,
  parameter bit OVF_GUARD    = 1,
  parameter bit UNF_GUARD    = 1,
  parameter bit WR_WHEN_FULL = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  output logic          wr_acc,
  output logic          rd_acc,
  output logic [AW-1:0] waddr,
  output logic [AW-1:0] raddr,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  import sfifo_pkg::*;

  localparam bit PASS_OK = WR_WHEN_FULL && OVF_GUARD;

  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, cnt_nxt;
  logic          full_q, empty_q;

  assign rd_acc  = rd_req && !clr && (!empty_q || !UNF_GUARD);
  assign wr_acc  = wr_req && !clr && (!full_q || !OVF_GUARD || (PASS_OK && rd_acc));
  assign cnt_nxt = CW'(level_next(32'(cnt), wr_acc, rd_acc));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else if (clr) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      full_q  <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      if (wr_acc) wptr <= AW'(ring_next(32'(wptr), DEPTH));
      if (rd_acc) rptr <= AW'(ring_next(32'(rptr), DEPTH));
      cnt     <= cnt_nxt;
      full_q  <= (cnt_nxt == CW'(DEPTH));
      empty_q <= (cnt_nxt == '0);
    end
  end

  assign waddr = wptr;
  assign raddr = rptr;
  assign level = cnt;
  assign full  = full_q;
  assign empty = empty_q;

  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (cnt == CW'(DEPTH)) && empty_q == (cnt == '0)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1 || cnt + 1'b1 == $past(cnt))); // R3

  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (empty_q && cnt == '0 && !full_q)); // R10

  generate
    if (OVF_GUARD) begin : g_ovf
      AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_req && !rd_req && !clr) |=> (full_q && $stable(wptr))); // R7
    end
    if (UNF_GUARD) begin : g_unf
      AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_q && rd_req && !clr) |=> $stable(rptr)); // R8
    end
    if (PASS_OK) begin : g_pass
      AST_PASS_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (full_q && wr_req && rd_req && !clr) |=> full_q); // R9
    end
  endgenerate
endmodule

// File: rtl/sfifo_store.sv
module sfifo_store #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/sfifo_ostage.sv
module sfifo_ostage #(
  parameter int DW     = 8,
  parameter bit ENABLE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  generate
    if (ENABLE) begin : g_reg
      logic [DW-1:0] q_r;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_r <= '0;
        else        q_r <= d;
      end
      assign q = q_r;
    end else begin : g_wire
      assign q = d;
    end
  endgenerate
endmodule

// File: rtl/sfifo_guarded.sv
module sfifo_guarded #(
  parameter int DW           = 8,
  parameter int DEPTH        = 8,
  parameter int AF_LEVEL     = 6,
  parameter int AE_LEVEL     = 2,
  parameter bit OVF_GUARD    = 1,
  parameter bit UNF_GUARD    = 1,
  parameter bit WR_WHEN_FULL = 0,
  parameter bit OUT_REG      = 0,
  parameter int AW           = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CW           = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          almost_full,
  output logic          almost_empty,
  output logic [CW-1:0] level
);
  import sfifo_pkg::*;

  logic          wr_acc, rd_acc;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] mem_q;

  sfifo_ctrl #(
    .DEPTH(DEPTH), .AW(AW), .CW(CW), .OVF_GUARD(OVF_GUARD),
    .UNF_GUARD(UNF_GUARD), .WR_WHEN_FULL(WR_WHEN_FULL)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .clr(clr), .wr_req(wr_req), .rd_req(rd_req),
    .wr_acc(wr_acc), .rd_acc(rd_acc), .waddr(waddr), .raddr(raddr),
    .level(level), .full(full), .empty(empty)
  );

  sfifo_store #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .we(wr_acc), .waddr(waddr), .wdata(wr_data),
    .re(rd_acc), .raddr(raddr), .rdata(mem_q)
  );

  sfifo_ostage #(.DW(DW), .ENABLE(OUT_REG)) u_ostage (
    .clk(clk), .rst_n(rst_n), .d(mem_q), .q(rd_data)
  );

  assign almost_full  = at_or_above(32'(level), AF_LEVEL);
  assign almost_empty = strictly_below(32'(level), AE_LEVEL);

  AST_AF_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (full && AF_LEVEL <= DEPTH) |-> almost_full); // R5
  AST_AE_AT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && AE_LEVEL > 0) |-> almost_empty); // R6
endmodule

// File: tb/sim_sfifo_guarded.sv
module sim_sfifo_guarded;
  localparam int DEP = 8;

  logic clk = 0;
  logic rst_n = 0;
  always #2 clk = ~clk;

  logic       clr0 = 0, wr0 = 0, rd0 = 0, clr1 = 0, wr1 = 0, rd1 = 0;
  logic [7:0] din0 = 0, din1 = 0, dout0, dout1;
  logic       f0, e0, af0, ae0, f1, e1, af1, ae1;
  logic [3:0] lv0, lv1;

  sfifo_guarded #(.DW(8), .DEPTH(DEP), .AF_LEVEL(6), .AE_LEVEL(2), .OVF_GUARD(1),
    .UNF_GUARD(1), .WR_WHEN_FULL(1), .OUT_REG(0)) u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr0), .wr_req(wr0), .rd_req(rd0),
    .wr_data(din0), .rd_data(dout0), .full(f0), .empty(e0),
    .almost_full(af0), .almost_empty(ae0), .level(lv0));

  sfifo_guarded #(.DW(8), .DEPTH(DEP), .AF_LEVEL(5), .AE_LEVEL(3), .OVF_GUARD(0),
    .UNF_GUARD(0), .WR_WHEN_FULL(0), .OUT_REG(1)) u1 (
    .clk(clk), .rst_n(rst_n), .clr(clr1), .wr_req(wr1), .rd_req(rd1),
    .wr_data(din1), .rd_data(dout1), .full(f1), .empty(e1),
    .almost_full(af1), .almost_empty(ae1), .level(lv1));

  int tests = 0, fails = 0;
  int cnt0 = 0, cnt1 = 0;
  logic [7:0] q0[$], q1[$];
  bit pend1 = 0;
  logic [7:0] exp1;

  task automatic chk(bit ok, string tag, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Check level and all flags of one instance against the model.
  task automatic check_flags(int k);
    int c;
    c = (k == 0) ? cnt0 : cnt1;
    if (k == 0) begin
      chk(lv0 == 4'(c), "R3 level u0", int'(lv0), c);
      chk(f0 == (c == DEP) && e0 == (c == 0), "R4 full/empty u0", {f0, e0}, {c == DEP, c == 0});
      chk(af0 == (c >= 6), "R5 almost_full u0", af0, c >= 6);
      chk(ae0 == (c < 2), "R6 almost_empty u0", ae0, c < 2);
    end else begin
      chk(lv1 == 4'(c), "R3 level u1", int'(lv1), c);
      chk(f1 == (c == DEP) && e1 == (c == 0), "R4 full/empty u1", {f1, e1}, {c == DEP, c == 0});
      chk(af1 == (c >= 5), "R5 almost_full u1", af1, c >= 5);
      chk(ae1 == (c < 3), "R6 almost_empty u1", ae1, c < 3);
    end
  endtask

  // Driver: one clock of stimulus on instance k, with the model updated and
  // scoreboard items pushed and popped.
  task automatic op(int k, bit w, bit r, bit c, logic [7:0] d);
    bit ra, wa;
    int n;
    logic [7:0] e;
    n = (k == 0) ? cnt0 : cnt1;
    ra = r && (n > 0 || k == 1);
    wa = w && (n < DEP || (k == 0 && ra) || k == 1);
    if (k == 0) begin wr0 = w; rd0 = r; clr0 = c; din0 = d; end
    else        begin wr1 = w; rd1 = r; clr1 = c; din1 = d; end
    @(posedge clk);
    @(negedge clk);
    wr0 = 0; rd0 = 0; clr0 = 0; wr1 = 0; rd1 = 0; clr1 = 0;
    if (pend1) begin
      chk(dout1 == exp1, "R2 u1 data two edges after read", int'(dout1), int'(exp1));
      pend1 = 0;
    end
    if (c) begin
      n = 0;
      if (k == 0) q0.delete(); else q1.delete();
    end else begin
      if (ra) begin
        if (k == 0) begin
          e = q0.pop_front();
          chk(dout0 == e, "R1 u0 data one edge after read", int'(dout0), int'(e));
        end else begin
          exp1 = q1.pop_front();
          pend1 = 1;
        end
      end
      if (wa) begin
        if (k == 0) q0.push_back(d); else q1.push_back(d);
      end
      n = n + (wa ? 1 : 0) - (ra ? 1 : 0);
    end
    if (k == 0) cnt0 = n; else cnt1 = n;
    check_flags(k);
  endtask

  initial begin
    #(200000 * 4);
    fails++; tests++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk(lv0 == 0 && e0 && !f0, "R4 reset state u0", int'(lv0), 0);
    chk(lv1 == 0 && e1 && !f1, "R4 reset state u1", int'(lv1), 0);
    rst_n = 1;
    @(negedge clk);

    // Guarded variant: fill through every level.
    for (int i = 0; i < DEP; i++) op(0, 1, 0, 0, 8'(8'h10 + i));
    op(0, 1, 0, 0, 8'hEE);   // write while full: must be dropped
    chk(lv0 == 4'(DEP) && f0, "R7 write on full ignored", int'(lv0), DEP);
    op(0, 1, 1, 0, 8'h55);   // read and write together while full
    chk(f0, "R9 stays full on pass-through", f0, 1);
    op(0, 0, 1, 0, 0);
    op(0, 1, 1, 0, 8'h66);   // mid-level read and write together
    chk(lv0 == 4'(DEP - 1), "R3 level unchanged on paired op", int'(lv0), DEP - 1);
    for (int i = 0; i < DEP + 2; i++) op(0, 0, 1, 0, 0);   // last reads on empty
    chk(lv0 == 0 && e0, "R8 read on empty ignored", int'(lv0), 0);
    op(0, 1, 1, 0, 8'hA7);   // read and write together while empty: write only
    chk(lv0 == 1, "R8 paired op on empty stores only", int'(lv0), 1);
    op(0, 0, 1, 0, 0);
    for (int i = 0; i < 3; i++) op(0, 1, 0, 0, 8'(8'h30 + i));
    op(0, 1, 0, 1, 8'hFF);   // clear beats the write
    chk(lv0 == 0 && e0 && !f0, "R10 clear empties u0", int'(lv0), 0);
    op(0, 1, 0, 0, 8'h44);
    op(0, 0, 1, 0, 0);

    // Unguarded variant: the bench keeps to the request rules.
    for (int i = 0; i < DEP; i++) op(1, 1, 0, 0, 8'(8'h80 + i * 3));
    op(1, 0, 1, 0, 0);
    op(1, 1, 1, 0, 8'hC1);
    for (int i = 0; i < DEP - 1; i++) op(1, 0, 1, 0, 0);
    op(1, 0, 0, 0, 0);
    chk(lv1 == 0 && e1, "R4 u1 drained", int'(lv1), 0);
    op(1, 1, 0, 0, 8'h21);
    op(1, 1, 0, 0, 8'h22);
    op(1, 0, 0, 1, 0);
    chk(lv1 == 0 && e1 && !f1, "R10 clear empties u1", int'(lv1), 0);
    op(1, 1, 0, 0, 8'h99);
    op(1, 0, 1, 0, 0);
    op(1, 0, 0, 0, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule